// File: doc/BRIEF.md
# Gating Preset Down-Counter

This block counts qualified input pulses downward from a programmable preset and lets each counted pulse through to its output. When the count reaches zero, the counter stops there, raises a done flag and drops every further pulse, so the block delivers exactly a preset number of pulses and then closes. The block accepts pulses at up to one per clock, which covers a 10 MHz stream at the intended clock rate.

A new run starts on a reload request. The request can come from a single-cycle strobe on the bus side, or from a front-panel level that is asynchronous to the clock and acts on its rising edge. The preset is a register written through a simple write-enable port, and the running count is always visible on a readback output. Input level conversion and bus address decoding sit outside this block.

Top module: `preset_gate_counter`

## Requirements
- R1: After reset the count reads 0x00989680, the preset register holds 0x00989680, done_o is low and pulse_o is low.
- R2: A pulse_i high in a cycle with a nonzero count and no reload decrements count_o by one after that clock edge; pulses on consecutive cycles are each counted.
- R3: Each counted pulse drives pulse_o high for exactly the one cycle after the edge that counted it; pulse_o is low in every other cycle.
- R4: done_o is high exactly while count_o is zero, and without a reload the count stays at zero.
- R5: A pulse_i arriving while the count is zero is blocked: pulse_o stays low and count_o stays zero.
- R6: bus_reload_i high for one cycle copies the preset register into count_o at the next edge, and pulse_o is low in the following cycle.
- R7: When a reload and a pulse_i land in the same cycle, the reload wins: count_o becomes the preset and the pulse is neither counted nor passed.
- R8: panel_reload_i is asynchronous; its rising edge reloads the count at the third rising clock edge after it goes high. Holding it high or letting it fall causes no further reload.
- R9: preset_we_i high loads preset_d_i into the preset register at the next edge; a reload in that same cycle still loads the previous preset.
- R10: Reloading with a preset of zero puts the count at zero, asserts done_o and blocks pulses at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Synchronous input pulse, one count per high cycle |
| bus_reload_i | input | 1 | Single-cycle reload strobe from the bus side |
| panel_reload_i | input | 1 | Asynchronous front-panel reload level, acts on rising edge |
| preset_we_i | input | 1 | Preset register write enable |
| preset_d_i | input | CNT_W (32) | Preset write data |
| pulse_o | output | 1 | Gated pulse output |
| done_o | output | 1 | High while the count is zero |
| count_o | output | CNT_W (32) | Current count readback |

## Verification
Counting, gating and bus reload all take effect at the first clock edge after the stimulus, so count_o, pulse_o and done_o are due one edge later; the bench drives inputs on the falling edge and compares every output on the following falling edge against a cycle model kept in the bench. The front-panel reload passes two synchronizer flops and an edge detector, so its result is due at the third rising edge; the bench checks that the count is still unchanged after the first and second edges and loaded after the third. Small presets from zero to five are swept with continuous and alternating pulse trains past zero, followed by a long pseudo-random run of pulses and bus reloads.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  parameter int unsigned CNT_W_DEF   = 32;
  parameter int unsigned SYNC_N_DEF  = 2;
  parameter logic [31:0] PRESET_DEF  = 32'h0098_9680;
endpackage

// File: rtl/pgc_sync_edge.sv
module pgc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= async_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pgc_preset_reg.sv
module pgc_preset_reg #(
  parameter int unsigned       CNT_W   = 32,
  parameter logic [CNT_W-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] d_i,
  output logic [CNT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/pgc_core.sv
module pgc_core #(
  parameter int unsigned       CNT_W   = 32,
  parameter logic [CNT_W-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pass_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pass_q;
  logic             take;

  assign zero_o = (cnt_q == '0);
  // reload has priority over a coincident pulse
  assign take   = pulse_i & ~zero_o & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RST_VAL;
      pass_q <= 1'b0;
    end else begin
      pass_q <= take;
      if (reload_i)  cnt_q <= preset_i;
      else if (take) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign pass_o  = pass_q;
endmodule

// File: rtl/preset_gate_counter.sv
module preset_gate_counter #(
  parameter int unsigned       CNT_W      = pgc_pkg::CNT_W_DEF,
  parameter int unsigned       SYNC_N     = pgc_pkg::SYNC_N_DEF,
  parameter logic [CNT_W-1:0]  PRESET_RST = CNT_W'(pgc_pkg::PRESET_DEF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             bus_reload_i,
  input  logic             panel_reload_i,
  input  logic             preset_we_i,
  input  logic [CNT_W-1:0] preset_d_i,
  output logic             pulse_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic             panel_rise;
  logic             reload_w;
  logic [CNT_W-1:0] preset_q;

  pgc_sync_edge #(.STAGES(SYNC_N)) u_panel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(panel_reload_i),
    .rise_o (panel_rise)
  );

  pgc_preset_reg #(.CNT_W(CNT_W), .RST_VAL(PRESET_RST)) u_preset (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (preset_we_i),
    .d_i   (preset_d_i),
    .q_o   (preset_q)
  );

  assign reload_w = bus_reload_i | panel_rise;

  pgc_core #(.CNT_W(CNT_W), .RST_VAL(PRESET_RST)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_i),
    .reload_i(reload_w),
    .preset_i(preset_q),
    .count_o (count_o),
    .pass_o  (pulse_o),
    .zero_o  (done_o)
  );
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pulse_i,
  input logic             bus_reload_i,
  input logic             panel_reload_i,
  input logic             reload_w,
  input logic [CNT_W-1:0] preset_q,
  input logic             pulse_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o
);
  AST_COUNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i && !reload_w && (count_o != '0) |=> (count_o == $past(count_o) - 1'b1) && pulse_o); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i && !reload_w |=> $stable(count_o) && !pulse_o); // R3

  AST_ZERO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !reload_w |=> done_o && (count_o == '0)); // R4

  AST_BLOCK_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) && !reload_w |=> !pulse_o); // R5

  AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_w |=> (count_o == $past(preset_q)) && !pulse_o); // R7

  AST_BUS_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reload_i |-> reload_w); // R6

  AST_PANEL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_w && !bus_reload_i |-> $past(panel_reload_i, 2)); // R8
endmodule

bind preset_gate_counter pgc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pulse_i       (pulse_i),
  .bus_reload_i  (bus_reload_i),
  .panel_reload_i(panel_reload_i),
  .reload_w      (reload_w),
  .preset_q      (preset_q),
  .pulse_o       (pulse_o),
  .done_o        (done_o),
  .count_o       (count_o)
);

// File: tb/preset_gate_counter_tb.sv
module preset_gate_counter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pulse_i = 1'b0;
  logic        bus_reload_i = 1'b0;
  logic        panel_reload_i = 1'b0;
  logic        preset_we_i = 1'b0;
  logic [31:0] preset_d_i = '0;
  logic        pulse_o;
  logic        done_o;
  logic [31:0] count_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] exp_cnt;
  logic [31:0] preset_m;
  logic        exp_pass;

  always #10 clk_i = ~clk_i;

  preset_gate_counter u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pulse_i       (pulse_i),
    .bus_reload_i  (bus_reload_i),
    .panel_reload_i(panel_reload_i),
    .preset_we_i   (preset_we_i),
    .preset_d_i    (preset_d_i),
    .pulse_o       (pulse_o),
    .done_o        (done_o),
    .count_o       (count_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "count_o", count_o, exp_cnt);
    chk(tag, "pulse_o", {31'd0, pulse_o}, {31'd0, exp_pass});
    chk(tag, "done_o", {31'd0, done_o}, {31'd0, exp_cnt == 32'd0});
  endtask

  // drive on falling edge, model one rising edge, compare on next falling edge
  task automatic step(input logic p, input logic rl, input logic we, input logic [31:0] d, input string tag);
    pulse_i = p; bus_reload_i = rl; preset_we_i = we; preset_d_i = d;
    @(posedge clk_i);
    if (rl) begin
      exp_cnt = preset_m; exp_pass = 1'b0;
    end else if (p && exp_cnt != 32'd0) begin
      exp_cnt = exp_cnt - 32'd1; exp_pass = 1'b1;
    end else begin
      exp_pass = 1'b0;
    end
    if (we) preset_m = d;
    @(negedge clk_i);
    pulse_i = 1'b0; bus_reload_i = 1'b0; preset_we_i = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    exp_cnt = 32'h0098_9680; preset_m = 32'h0098_9680; exp_pass = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1");

    // R1: default preset reaches count via a reload after some counting
    step(1'b1, 1'b0, 1'b0, 32'd0, "R2");
    step(1'b1, 1'b0, 1'b0, 32'd0, "R2 R3");
    step(1'b0, 1'b0, 1'b0, 32'd0, "R3");
    step(1'b1, 1'b0, 1'b0, 32'd0, "R2");
    step(1'b0, 1'b1, 1'b0, 32'd0, "R1 R6");

    // R9: write and reload in the same cycle take the old preset
    step(1'b0, 1'b1, 1'b1, 32'd7, "R9");
    step(1'b0, 1'b1, 1'b0, 32'd0, "R9 R6");

    // sweep small presets with continuous pulse trains past zero
    for (int p = 0; p <= 5; p++) begin
      step(1'b0, 1'b0, 1'b1, p, "R9");
      step(1'b0, 1'b1, 1'b0, 32'd0, (p == 0) ? "R10" : "R6");
      for (int i = 0; i < p + 3; i++)
        step(1'b1, 1'b0, 1'b0, 32'd0, (exp_cnt == 32'd0) ? "R5 R4" : "R2 R3");
    end

    // alternating pulses
    step(1'b0, 1'b0, 1'b1, 32'd4, "R9");
    step(1'b0, 1'b1, 1'b0, 32'd0, "R6");
    for (int i = 0; i < 12; i++)
      step(i[0] == 1'b0, 1'b0, 1'b0, 32'd0, (exp_cnt == 32'd0) ? "R4 R5" : "R2 R3");

    // R7: reload and pulse together
    step(1'b0, 1'b0, 1'b1, 32'd3, "R9");
    step(1'b0, 1'b1, 1'b0, 32'd0, "R6");
    step(1'b1, 1'b0, 1'b0, 32'd0, "R2");
    step(1'b1, 1'b1, 1'b0, 32'd0, "R7");
    step(1'b1, 1'b0, 1'b0, 32'd0, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 32'd0, "R5");
    step(1'b1, 1'b1, 1'b0, 32'd0, "R7");

    // R8: panel reload latency, level hold and fall
    step(1'b0, 1'b0, 1'b1, 32'd9, "R9");
    panel_reload_i = 1'b1;
    @(negedge clk_i); chk_all("R8");
    @(negedge clk_i); chk_all("R8");
    @(negedge clk_i); exp_cnt = preset_m; chk_all("R8");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 32'd0, "R8 R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 32'd0, "R8");
    panel_reload_i = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 32'd0, "R8");

    // pseudo-random pulses and bus reloads
    step(1'b0, 1'b0, 1'b1, 32'd5, "R9");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[7], lfsr[4:0] == 5'd3, 1'b0, 32'd0, "R2 R5 R6 R7");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule